// File: doc/BRIEF.md
# Dual-Rail Link Encoder and Completion Detector

This block carries a binary word across a four-phase dual-rail channel. Every data bit travels on two wires: a true rail and a false rail. The pair (true=1, false=0) carries a one. The pair (true=0, false=1) carries a zero. Both rails low is the empty spacer, which carries nothing. Both rails high is never legal. Data and request share these wires, so there is no separate request line. The receiver works out from the rails alone when a word has fully arrived, and when it has fully drained back to the spacer.

The transmit half accepts a word through a ready/valid pair and drives its codeword. It holds the codeword until the far end acknowledges. It then returns every bit to the spacer and waits for the acknowledge to fall before it accepts another word. Its FSM has three states:
- `TX_IDLE`: spacer driven, ready high.
- `TX_SEND`: codeword driven.
- `TX_RTZ`: spacer driven, waiting for the acknowledge to drop.

Its transitions are:
- `TX_IDLE`→`TX_SEND` on an accepted word.
- `TX_SEND`→`TX_RTZ` when the acknowledge is high.
- `TX_RTZ`→`TX_IDLE` when the acknowledge is low.

The receive half registers the incoming rails once per clock. It classifies each sampled bit as valid, empty or illegal. Its FSM has two states: `RX_EMPTY` (acknowledge low) and `RX_FULL` (acknowledge high). Its transitions are:
- `RX_EMPTY`→`RX_FULL` when every sampled bit is valid. On this transition the decoded word is presented with a one-cycle strobe.
- `RX_FULL`→`RX_EMPTY` when every sampled bit is empty.

A word that is only partly present or partly drained leaves the state alone. Two sticky flags record protocol violations seen on the receive rails.

Top module: `dr_link`

## Requirements
- R1: After reset:
  - both transmit rail vectors are all zero;
  - `in_ready` is 1;
  - `rx_ack`, `out_valid`, `err_code` and `err_swap` are 0.
- R2: While the transmitter drives a word, bit i has `tx_rail_t[i]` equal to the data bit and `tx_rail_f[i]` equal to its inverse. A transmit bit never has both rails high.
- R3: The transmitter holds the same codeword for as long as `tx_ack` is low. One cycle after `tx_ack` is seen high, it drives all rails to 0.
- R4: `in_ready` goes low the cycle after a word is accepted. It stays low until `tx_ack` has been seen low after the spacer, and is 1 again one cycle after that. While `in_ready` is 1 the transmit rails are all zero.
- R5: `rx_ack` rises two clock edges after every receive bit first shows a valid codeword: one edge to sample the rails and one for the FSM.
- R6: While only some receive bits are valid and the rest empty, `rx_ack` keeps its value. This holds both while filling from empty and while draining from full.
- R7: `rx_ack` falls two clock edges after every receive bit shows the spacer.
- R8: `out_valid` pulses for exactly one cycle, in the cycle `rx_ack` rises. `out_data` then holds the sampled true rails, which are the decoded word.
- R9: A sample with both rails of any bit high sets `err_code`. The flag stays set until reset.
- R10: A bit that changes from one valid codeword directly to the other between two consecutive samples sets `err_swap`. The flag stays set until reset. A change through the spacer does not set it.
- R11: When the transmit rails are looped to the receive rails and `rx_ack` to `tx_ack`, every accepted word arrives unchanged on `out_data`, with one `out_valid` pulse per word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | W | Word to transmit |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Transmitter accepts a word this cycle |
| tx_rail_t | output | W | Transmit true rails |
| tx_rail_f | output | W | Transmit false rails |
| tx_ack | input | 1 | Acknowledge from the far receiver |
| rx_rail_t | input | W | Receive true rails |
| rx_rail_f | input | W | Receive false rails |
| rx_ack | output | 1 | Acknowledge to the far transmitter |
| out_data | output | W | Decoded received word |
| out_valid | output | 1 | One-cycle strobe for out_data |
| err_code | output | 1 | Sticky: both rails of a bit seen high |
| err_swap | output | 1 | Sticky: valid-to-valid change seen on a bit |

## Verification
The following are checked by assertions on every cycle:
- the transmitter never drives an illegal or half-filled codeword;
- it holds its codeword while unacknowledged;
- ready implies a spacer on the transmit rails;
- the acknowledge changes only after a complete word or a complete spacer has been sampled;
- the strobe coincides with a rising acknowledge;
- both error flags are sticky.

Only the bench scenarios can show the following:
- exact latencies;
- that the decoded value equals the word sent;
- that partial words leave the acknowledge alone;
- that each violation sets its own flag and only that flag;
- that reset clears the flags.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_RTZ  = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_e;

endpackage

// File: rtl/dr_encoder.sv
module dr_encoder
    import dr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         tx_ack,
    output logic [W-1:0] rail_t,
    output logic [W-1:0] rail_f
);

    tx_state_e    state, nxt;
    logic [W-1:0] hold;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    // word held while the codeword is on the rails
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hold <= '0;
        else if (in_valid && in_ready) hold <= in_data;
    end

    // next state and outputs
    always_comb begin
        nxt      = state;
        in_ready = 1'b0;
        rail_t   = '0;
        rail_f   = '0;
        unique case (state)
            TX_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) nxt = TX_SEND;
            end
            TX_SEND: begin
                rail_t = hold;
                rail_f = ~hold;
                if (tx_ack) nxt = TX_RTZ;
            end
            TX_RTZ: begin
                if (!tx_ack) nxt = TX_IDLE;
            end
            default: nxt = TX_IDLE;
        endcase
    end

endmodule

// File: rtl/dr_rail_sampler.sv
module dr_rail_sampler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rail_t,
    input  logic [W-1:0] rail_f,
    output logic [W-1:0] smp_t,
    output logic [W-1:0] smp_f,
    output logic         all_valid,
    output logic         all_empty,
    output logic         err_code,
    output logic         err_swap
);

    logic [W-1:0] prv_t, prv_f;
    logic [W-1:0] bit_valid, bit_empty, bit_bad, bit_swap;

    // one sample of the rails per clock, plus the previous sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_t <= '0;
            smp_f <= '0;
            prv_t <= '0;
            prv_f <= '0;
        end else begin
            smp_t <= rail_t;
            smp_f <= rail_f;
            prv_t <= smp_t;
            prv_f <= smp_f;
        end
    end

    // per-bit classification
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_valid[i] = smp_t[i] ^ smp_f[i];
        assign bit_empty[i] = ~(smp_t[i] | smp_f[i]);
        assign bit_bad[i]   = smp_t[i] & smp_f[i];
        assign bit_swap[i]  = (prv_t[i] ^ prv_f[i]) & bit_valid[i]
                              & (prv_t[i] ^ smp_t[i]);
    end

    assign all_valid = &bit_valid;
    assign all_empty = &bit_empty;

    // sticky violation flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_code <= 1'b0;
            err_swap <= 1'b0;
        end else begin
            if (|bit_bad)  err_code <= 1'b1;
            if (|bit_swap) err_swap <= 1'b1;
        end
    end

endmodule

// File: rtl/dr_completion.sv
module dr_completion
    import dr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         all_valid,
    input  logic         all_empty,
    input  logic [W-1:0] word,
    output logic         ack,
    output logic [W-1:0] out_data,
    output logic         out_valid
);

    rx_state_e state, nxt;
    logic      capture;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_EMPTY;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt     = state;
        ack     = 1'b0;
        capture = 1'b0;
        unique case (state)
            RX_EMPTY: begin
                if (all_valid) begin
                    nxt     = RX_FULL;
                    capture = 1'b1;
                end
            end
            RX_FULL: begin
                ack = 1'b1;
                if (all_empty) nxt = RX_EMPTY;
            end
            default: nxt = RX_EMPTY;
        endcase
    end

    // decoded word and its strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= capture;
            if (capture) out_data <= word;
        end
    end

endmodule

// File: rtl/dr_link.sv
module dr_link #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    output logic [W-1:0] tx_rail_t,
    output logic [W-1:0] tx_rail_f,
    input  logic         tx_ack,
    input  logic [W-1:0] rx_rail_t,
    input  logic [W-1:0] rx_rail_f,
    output logic         rx_ack,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    output logic         err_code,
    output logic         err_swap
);

    logic [W-1:0] smp_t, smp_f;
    logic         all_valid, all_empty;

    dr_encoder #(.W(W)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .tx_ack   (tx_ack),
        .rail_t   (tx_rail_t),
        .rail_f   (tx_rail_f)
    );

    dr_rail_sampler #(.W(W)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail_t    (rx_rail_t),
        .rail_f    (rx_rail_f),
        .smp_t     (smp_t),
        .smp_f     (smp_f),
        .all_valid (all_valid),
        .all_empty (all_empty),
        .err_code  (err_code),
        .err_swap  (err_swap)
    );

    dr_completion #(.W(W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .all_valid (all_valid),
        .all_empty (all_empty),
        .word      (smp_t),
        .ack       (rx_ack),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/dr_link_chk.sv
module dr_link_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_ready,
    input logic [W-1:0] tx_rail_t,
    input logic [W-1:0] tx_rail_f,
    input logic         tx_ack,
    input logic         rx_ack,
    input logic         out_valid,
    input logic         err_code,
    input logic         err_swap,
    input logic [W-1:0] smp_t,
    input logic [W-1:0] smp_f
);

    a_r2_tx_codeword: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_rail_t & tx_rail_f) == '0) &&
        (((tx_rail_t | tx_rail_f) == '0) || ((tx_rail_t ^ tx_rail_f) == '1)));

    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (((tx_rail_t | tx_rail_f) != '0) && !tx_ack)
        |=> ($stable(tx_rail_t) && $stable(tx_rail_f)));

    a_r4_ready_spacer: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> ((tx_rail_t | tx_rail_f) == '0));

    a_r5_ack_rise_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ack) |-> $past((smp_t ^ smp_f) == '1));

    a_r7_ack_fall_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ack) |-> $past((smp_t | smp_f) == '0));

    a_r8_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rx_ack && !$past(rx_ack)));

    a_r9_code_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_code) |-> err_code);

    a_r10_swap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_swap) |-> err_swap);

endmodule

bind dr_link dr_link_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .tx_rail_t (tx_rail_t),
    .tx_rail_f (tx_rail_f),
    .tx_ack    (tx_ack),
    .rx_ack    (rx_ack),
    .out_valid (out_valid),
    .err_code  (err_code),
    .err_swap  (err_swap),
    .smp_t     (smp_t),
    .smp_f     (smp_f)
);

// File: tb/tb_dr_link.sv
`timescale 1ns/1ps
module tb_dr_link;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] tx_rail_t, tx_rail_f;
    logic         tx_ack;
    logic [W-1:0] rx_rail_t, rx_rail_f;
    logic         rx_ack;
    logic [W-1:0] out_data;
    logic         out_valid;
    logic         err_code, err_swap;

    logic         lb = 1'b0;
    logic [W-1:0] drv_t = '0, drv_f = '0;
    logic         drv_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign rx_rail_t = lb ? tx_rail_t : drv_t;
    assign rx_rail_f = lb ? tx_rail_f : drv_f;
    assign tx_ack    = lb ? rx_ack    : drv_ack;

    dr_link #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .tx_rail_t(tx_rail_t), .tx_rail_f(tx_rail_f), .tx_ack(tx_ack),
        .rx_rail_t(rx_rail_t), .rx_rail_f(rx_rail_f), .rx_ack(rx_ack),
        .out_data(out_data), .out_valid(out_valid),
        .err_code(err_code), .err_swap(err_swap)
    );

    function automatic logic [W-1:0] enc_t(input logic [W-1:0] w);
        return w;
    endfunction
    function automatic logic [W-1:0] enc_f(input logic [W-1:0] w);
        return ~w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic drive(input logic [W-1:0] t, input logic [W-1:0] f);
        drv_t = t;
        drv_f = f;
    endtask

    // loopback transfer of one word (R2, R4, R8, R11)
    task automatic send_loop(input logic [W-1:0] w);
        bit got = 0;
        bit enc_seen = 0;
        int pulses = 0;
        while (!in_ready) @(negedge clk);
        in_data  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(!in_ready, "R4 ready low after accept", {31'd0, in_ready}, 32'd0);
        for (int k = 0; k < 30; k++) begin
            if (!enc_seen && (tx_rail_t | tx_rail_f) != '0) begin
                enc_seen = 1;
                chk(tx_rail_t == enc_t(w) && tx_rail_f == enc_f(w), "R2 encoding",
                    {16'd0, tx_rail_t, tx_rail_f}, {16'd0, enc_t(w), enc_f(w)});
            end
            if (out_valid) begin
                pulses++;
                got = 1;
                chk(out_data == w, "R11 loopback word", {24'd0, out_data}, {24'd0, w});
            end
            if (in_ready) break;
            @(negedge clk);
        end
        chk(got && pulses == 1, "R8 one strobe per word", pulses, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        chk(tx_rail_t == '0 && tx_rail_f == '0, "R1 tx rails", {16'd0, tx_rail_t, tx_rail_f}, 32'd0);
        chk(in_ready == 1'b1, "R1 in_ready", {31'd0, in_ready}, 32'd1);
        chk({rx_ack, out_valid, err_code, err_swap} == 4'b0, "R1 rx outputs",
            {28'd0, rx_ack, out_valid, err_code, err_swap}, 32'd0);

        // R3/R4 directed transmit handshake with a held-low acknowledge
        lb = 1'b0;
        drv_ack = 1'b0;
        in_data = 8'hA5;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk(tx_rail_t == 8'hA5 && tx_rail_f == 8'h5A, "R3 hold while unacked",
            {16'd0, tx_rail_t, tx_rail_f}, 32'hA55A);
        drv_ack = 1'b1;
        @(negedge clk);
        chk(tx_rail_t == '0 && tx_rail_f == '0, "R3 spacer after ack",
            {16'd0, tx_rail_t, tx_rail_f}, 32'd0);
        repeat (3) @(negedge clk);
        chk(!in_ready, "R4 ready low while ack high", {31'd0, in_ready}, 32'd0);
        drv_ack = 1'b0;
        @(negedge clk);
        chk(in_ready, "R4 ready after ack low", {31'd0, in_ready}, 32'd1);

        // R5/R8 receive a full word
        drive(8'h3C, 8'hC3);
        @(negedge clk);
        chk(!rx_ack, "R5 ack not yet", {31'd0, rx_ack}, 32'd0);
        @(negedge clk);
        chk(rx_ack, "R5 ack after two edges", {31'd0, rx_ack}, 32'd1);
        chk(out_valid && out_data == 8'h3C, "R8 strobe and data",
            {23'd0, out_valid, out_data}, {23'd0, 1'b1, 8'h3C});
        @(negedge clk);
        chk(!out_valid, "R8 strobe one cycle", {31'd0, out_valid}, 32'd0);

        // R6 partial drain keeps ack high
        drive(8'h0C, 8'h03);
        repeat (4) @(negedge clk);
        chk(rx_ack, "R6 partial drain holds ack", {31'd0, rx_ack}, 32'd1);

        // R7 full spacer drops ack
        drive('0, '0);
        @(negedge clk);
        chk(rx_ack, "R7 ack not yet low", {31'd0, rx_ack}, 32'd1);
        @(negedge clk);
        chk(!rx_ack, "R7 ack low after two edges", {31'd0, rx_ack}, 32'd0);

        // R6 partial fill keeps ack low, no strobe
        drive(8'h01, 8'h10);
        repeat (4) @(negedge clk);
        chk(!rx_ack && !out_valid, "R6 partial fill holds ack", {30'd0, rx_ack, out_valid}, 32'd0);
        drive('0, '0);
        repeat (3) @(negedge clk);

        // R10 direct swap on one bit
        chk(!err_swap, "R10 clear before swap", {31'd0, err_swap}, 32'd0);
        drive(8'hF0, 8'h0F);
        @(negedge clk);
        drive(8'hF1, 8'h0E);
        repeat (3) @(negedge clk);
        chk(err_swap, "R10 swap flagged", {31'd0, err_swap}, 32'd1);
        chk(!err_code, "R9 swap does not set code flag", {31'd0, err_code}, 32'd0);

        // R10 change through spacer not flagged (after reset)
        drive('0, '0);
        do_reset();
        drive(8'hF0, 8'h0F);
        @(negedge clk);
        drive('0, '0);
        @(negedge clk);
        drive(8'h0F, 8'hF0);
        repeat (3) @(negedge clk);
        chk(!err_swap, "R10 via spacer not flagged", {31'd0, err_swap}, 32'd0);
        drive('0, '0);
        repeat (3) @(negedge clk);

        // R9 illegal code, sticky, cleared by reset
        drive(8'h80, 8'h80);
        @(negedge clk);
        drive('0, '0);
        @(negedge clk);
        chk(err_code, "R9 illegal code flagged", {31'd0, err_code}, 32'd1);
        repeat (4) @(negedge clk);
        chk(err_code, "R9 flag sticky", {31'd0, err_code}, 32'd1);
        do_reset();
        chk(!err_code && !err_swap, "R9 reset clears flags", {30'd0, err_code, err_swap}, 32'd0);

        // R11 loopback: corners then random
        lb = 1'b1;
        send_loop('0);
        send_loop('1);
        for (int n = 0; n < 40; n++) begin
            repeat ($urandom % 3) @(negedge clk);
            send_loop(W'($urandom));
        end
        chk(!err_code && !err_swap, "R11 no violations in loopback",
            {30'd0, err_code, err_swap}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule